// File: doc/BRIEF.md
# Completion versus posted-write ordering gate

This block sits at the head of a bridge's completion queue and decides, cycle by cycle, whether the read completion at the head may leave now or must wait behind posted writes travelling in the same direction. Each posted write is stamped at enqueue with a sequence tag that wraps and keeps increasing. Each completion carries a fence tag: the tag that the next posted write would have received when the completion was created. A strictly ordered completion may go only once no pending write is older than its fence.

Relaxed ordering lets a completion pass older posted writes. It applies only to completions presented on the primary interface, and only after the first completion of the same read transaction has been delivered. For requests issued in conventional mode, a configuration bit selects relaxed ordering. For requests issued in PCI-X mode, the relaxed-ordering bit of the request's attribute field decides, and the configuration bit is ignored. A small table, indexed by transaction ID, records which transactions have already delivered their first completion. An entry is cleared when the transaction's last completion is granted.

The grant is combinational from registered state and the queue-head inputs. A stalled head holds its place and raises `cpl_stall` until its ordering condition is met. Taking the grant is the same as popping the head.

Top module: `cog_gate`

## Requirements
- R1: With `cpl_pcix_mode`=0 and `cfg_relax_en`=0, a valid completion is never granted while a pending write older than its fence exists, even if its transaction already delivered a completion.
- R2: With `cpl_on_primary`=1, `cpl_pcix_mode`=0 and `cfg_relax_en`=1, the first completion of a transaction still waits for older writes. Every later completion of that transaction is granted even when older writes are pending.
- R3: A completion with `cpl_on_primary`=0 is always strictly ordered, whatever the mode bits and the attribute say.
- R4: With `cpl_pcix_mode`=1, `cpl_attr_relaxed` alone selects relaxed (1) or strict (0) ordering, and `cfg_relax_en` has no effect.
- R5: A pending write is older than the completion when `pw_empty`=0 and the most significant bit of (`pw_oldest_tag` − `cpl_fence_tag`) modulo 2^TAG_W is 1. Without such a write, a valid completion is granted, including across tag wrap-around.
- R6: A granted completion with `cpl_last`=0 marks its transaction ID as having delivered its first completion. Marks on different IDs are independent.
- R7: A granted completion with `cpl_last`=1 clears the mark of its ID, so that the next completion on that ID is treated as a first completion. A single completion that is both first and last leaves the mark clear.
- R8: Synchronous active-high reset clears every mark. `cpl_grant` is 0 whenever `cpl_valid` is 0, and `cpl_stall` equals `cpl_valid` and not `cpl_grant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_relax_en | input | 1 | Relaxed-ordering enable for requests issued in conventional mode |
| cpl_valid | input | 1 | Completion queue head is valid |
| cpl_on_primary | input | 1 | Head completion is presented on the primary interface |
| cpl_pcix_mode | input | 1 | Originating request was issued in PCI-X mode |
| cpl_attr_relaxed | input | 1 | Relaxed-ordering bit from the request attribute field |
| cpl_tid | input | TID_W (3) | Transaction ID of the head completion |
| cpl_fence_tag | input | TAG_W (8) | Write tag that was next to be issued when the completion was created |
| cpl_last | input | 1 | Head completion is the final one of its transaction |
| pw_empty | input | 1 | No posted write is pending in this direction |
| pw_oldest_tag | input | TAG_W (8) | Tag of the oldest pending posted write |
| cpl_grant | output | 1 | Head completion may leave this cycle (pops the head) |
| cpl_stall | output | 1 | Head completion is valid but held |

## Verification
On every cycle, the assertions check that no grant passes an older write while the strict rule governs: secondary-side heads, conventional requests with relaxed ordering disabled, and first completions under any mode. They also check that no grant appears without a valid head, and how the first-completion table moves after a first grant, a last grant and a reset. Only the bench scenarios show that relaxed passing actually takes place when it should. The same holds for the attribute overriding the configuration bit in both directions, for the fence comparison across tag wrap-around, and for a retired ID going back to first-completion behaviour.

// File: rtl/cog_pkg.sv
package cog_pkg;

    // Geometry of the completion and posted-write queues.
    localparam int unsigned TAG_W = 8;
    localparam int unsigned TID_N = 8;
    localparam int unsigned TID_W = (TID_N > 1) ? $clog2(TID_N) : 1;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [TID_W-1:0] tid_t;

    // How the head completion is to be ordered against posted writes.
    typedef enum logic [1:0] {
        ORD_STRICT   = 2'd0,
        ORD_RELAX_IF = 2'd1   // relaxed once the first completion went out
    } ord_kind_e;

    // Mode information carried by the completion queue head.
    typedef struct packed {
        logic on_primary;
        logic pcix_mode;
        logic attr_relaxed;
    } cpl_mode_t;

    // Snapshot of the head needed for the ordering decision.
    typedef struct packed {
        logic      valid;
        cpl_mode_t mode;
        tid_t      tid;
        tag_t      fence;
        logic      last;
    } cpl_head_t;

    // A write tag a is older than fence f when (a - f) is negative modulo 2^TAG_W.
    function automatic logic tag_before(input tag_t a, input tag_t f);
        tag_t diff;
        diff = a - f;
        return diff[TAG_W-1];
    endfunction

endpackage

// File: rtl/cog_policy.sv
module cog_policy
    import cog_pkg::*;
(
    input  logic      cfg_relax_en,
    input  cpl_mode_t mode,
    output ord_kind_e kind
);

    logic want_relax;

    always_comb begin
        // Attribute takes precedence for PCI-X requests; config bit otherwise.
        if (mode.pcix_mode)
            want_relax = mode.attr_relaxed;
        else
            want_relax = cfg_relax_en;

        // Only the primary side may ever relax.
        if (mode.on_primary && want_relax)
            kind = ORD_RELAX_IF;
        else
            kind = ORD_STRICT;
    end

endmodule

// File: rtl/cog_tag_cmp.sv
module cog_tag_cmp
    import cog_pkg::*;
(
    input  logic pw_empty,
    input  tag_t pw_oldest_tag,
    input  tag_t fence,
    output logic older_pending
);

    always_comb begin
        older_pending = 1'b0;
        if (!pw_empty)
            older_pending = tag_before(pw_oldest_tag, fence);
    end

endmodule

// File: rtl/cog_first_track.sv
module cog_first_track
    import cog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  tid_t             upd_tid,
    input  logic             upd_last,
    input  tid_t             rd_tid,
    output logic             rd_done,
    output logic [TID_N-1:0] done_vec
);

    logic [TID_N-1:0] done_q;

    genvar gi;
    generate
        for (gi = 0; gi < TID_N; gi++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)
                    done_q[gi] <= 1'b0;
                else if (upd_en && (upd_tid == tid_t'(gi)))
                    done_q[gi] <= !upd_last;
            end
        end
    endgenerate

    assign rd_done  = done_q[rd_tid];
    assign done_vec = done_q;

    // R6: a non-final grant leaves its ID marked
    p_mark_after_first_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_last) |=> done_q[$past(upd_tid)]);

    // R7: a final grant leaves its ID clear
    p_clear_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && upd_last) |=> !done_q[$past(upd_tid)]);

    // R8: reset leaves the table empty
    p_reset_clears_r8: assert property (@(posedge clk)
        $past(rst) |-> (done_q == '0));

endmodule

// File: rtl/cog_gate.sv
module cog_gate
    import cog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_relax_en,
    input  logic             cpl_valid,
    input  logic             cpl_on_primary,
    input  logic             cpl_pcix_mode,
    input  logic             cpl_attr_relaxed,
    input  logic [TID_W-1:0] cpl_tid,
    input  logic [TAG_W-1:0] cpl_fence_tag,
    input  logic             cpl_last,
    input  logic             pw_empty,
    input  logic [TAG_W-1:0] pw_oldest_tag,
    output logic             cpl_grant,
    output logic             cpl_stall
);

    cpl_head_t        head;
    ord_kind_e        kind;
    logic             older_pending;
    logic             first_done;
    logic [TID_N-1:0] done_vec;
    logic             may_pass;

    always_comb begin
        head.valid             = cpl_valid;
        head.mode.on_primary   = cpl_on_primary;
        head.mode.pcix_mode    = cpl_pcix_mode;
        head.mode.attr_relaxed = cpl_attr_relaxed;
        head.tid               = cpl_tid;
        head.fence             = cpl_fence_tag;
        head.last              = cpl_last;
    end

    cog_policy u_policy (
        .cfg_relax_en (cfg_relax_en),
        .mode         (head.mode),
        .kind         (kind)
    );

    cog_tag_cmp u_cmp (
        .pw_empty      (pw_empty),
        .pw_oldest_tag (pw_oldest_tag),
        .fence         (head.fence),
        .older_pending (older_pending)
    );

    cog_first_track u_track (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (cpl_grant),
        .upd_tid  (head.tid),
        .upd_last (head.last),
        .rd_tid   (head.tid),
        .rd_done  (first_done),
        .done_vec (done_vec)
    );

    always_comb begin
        may_pass  = (kind == ORD_RELAX_IF) && first_done;
        cpl_grant = head.valid && (!older_pending || may_pass);
        cpl_stall = head.valid && !cpl_grant;
    end

    // R8: nothing is granted without a valid head
    p_no_idle_grant_r8: assert property (@(posedge clk) disable iff (rst)
        !cpl_valid |-> !cpl_grant);

    // R1: conventional request with relaxing off never passes an older write
    p_strict_cfg_r1: assert property (@(posedge clk) disable iff (rst)
        (cpl_grant && !cpl_pcix_mode && !cfg_relax_en) |-> !older_pending);

    // R2: a first completion never passes an older write
    p_first_ordered_r2: assert property (@(posedge clk) disable iff (rst)
        (cpl_grant && !done_vec[cpl_tid]) |-> !older_pending);

    // R3: secondary-side completions never pass an older write
    p_secondary_strict_r3: assert property (@(posedge clk) disable iff (rst)
        (cpl_grant && !cpl_on_primary) |-> !older_pending);

    // R4: PCI-X request with the attribute clear never passes an older write
    p_pcix_attr_strict_r4: assert property (@(posedge clk) disable iff (rst)
        (cpl_grant && cpl_pcix_mode && !cpl_attr_relaxed) |-> !older_pending);

endmodule

// File: tb/cog_gate_tb.sv
module cog_gate_tb;
    import cog_pkg::*;

    typedef struct packed {
        logic       valid;
        logic       pri;
        logic       pcix;
        logic       attr;
        logic       cfg;
        logic       last;
        logic [2:0] tid;
        logic [7:0] fence;
        logic       empty;
        logic [7:0] oldest;
        logic       exp_grant;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 19;
    // valid pri pcix attr cfg last tid fence empty oldest exp req
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,8'd0,   1'b1,8'd0,   1'b0,4'd8},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,8'd10,  1'b0,8'd5,   1'b0,4'd1},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,8'd10,  1'b0,8'd10,  1'b1,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,8'd20,  1'b0,8'd12,  1'b0,4'd1},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,3'd0,8'd20,  1'b0,8'd12,  1'b1,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'd0,8'd30,  1'b0,8'd25,  1'b0,4'd7},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'd1,8'd30,  1'b0,8'd25,  1'b0,4'd2},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'd1,8'd30,  1'b1,8'd25,  1'b1,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'd1,8'd40,  1'b0,8'd35,  1'b1,4'd2},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,3'd1,8'd40,  1'b0,8'd35,  1'b0,4'd3},
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,3'd1,8'd40,  1'b0,8'd35,  1'b0,4'd4},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd1,8'd40,  1'b0,8'd35,  1'b1,4'd4},
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,3'd2,8'd40,  1'b0,8'd35,  1'b0,4'd6},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,8'h02,  1'b0,8'hF0,  1'b0,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,8'hF0,  1'b0,8'h02,  1'b1,4'd5},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,3'd2,8'd50,  1'b0,8'd45,  1'b1,4'd6},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'd2,8'd50,  1'b0,8'd45,  1'b0,4'd7},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,3'd4,8'd60,  1'b1,8'd0,   1'b1,4'd7},
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,3'd4,8'd60,  1'b0,8'd55,  1'b0,4'd7}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_relax_en, cpl_valid, cpl_on_primary, cpl_pcix_mode, cpl_attr_relaxed;
    logic [2:0] cpl_tid;
    logic [7:0] cpl_fence_tag, pw_oldest_tag;
    logic       cpl_last, pw_empty;
    logic       cpl_grant, cpl_stall;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cog_gate u_dut (
        .clk              (clk),
        .rst              (rst),
        .cfg_relax_en     (cfg_relax_en),
        .cpl_valid        (cpl_valid),
        .cpl_on_primary   (cpl_on_primary),
        .cpl_pcix_mode    (cpl_pcix_mode),
        .cpl_attr_relaxed (cpl_attr_relaxed),
        .cpl_tid          (cpl_tid),
        .cpl_fence_tag    (cpl_fence_tag),
        .cpl_last         (cpl_last),
        .pw_empty         (pw_empty),
        .pw_oldest_tag    (pw_oldest_tag),
        .cpl_grant        (cpl_grant),
        .cpl_stall        (cpl_stall)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        cpl_valid        = v.valid;
        cpl_on_primary   = v.pri;
        cpl_pcix_mode    = v.pcix;
        cpl_attr_relaxed = v.attr;
        cfg_relax_en     = v.cfg;
        cpl_last         = v.last;
        cpl_tid          = v.tid;
        cpl_fence_tag    = v.fence;
        pw_empty         = v.empty;
        pw_oldest_tag    = v.oldest;
    endtask

    task automatic apply(input vec_t v, input string tag);
        @(negedge clk);
        drive(v);
        #2;
        check(tag, cpl_grant, v.exp_grant);
        check("R8 stall", cpl_stall, v.valid & ~v.exp_grant);
    endtask

    function automatic vec_t mk(input logic cfg, input logic last, input logic [2:0] tid,
                                input logic [7:0] fence, input logic empty,
                                input logic [7:0] oldest, input logic exp);
        vec_t v;
        v = '{1'b1,1'b1,1'b0,1'b0,cfg,last,tid,fence,empty,oldest,exp,4'd0};
        return v;
    endfunction

    initial begin
        drive('0);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R8 reset grant", cpl_grant, 1'b0);
        check("R8 reset stall", cpl_stall, 1'b0);

        // Table walk: R1 strict, R2 relaxed after first, R3 secondary,
        // R4 attribute override, R5 wrap, R6 per-ID marks, R7 retire.
        for (int i = 0; i < NVEC; i++) begin
            string t;
            t = $sformatf("R%0d vec%0d grant", VECS[i].req, i);
            apply(VECS[i], t);
        end

        // R8: mark ID 3, reset, then a relaxed completion on ID 3 must wait.
        apply(mk(1'b1, 1'b0, 3'd3, 8'd70, 1'b1, 8'd0, 1'b1), "R8 mark tid3");
        apply(mk(1'b1, 1'b0, 3'd3, 8'd70, 1'b0, 8'd65, 1'b1), "R2 tid3 relaxed");
        @(negedge clk);
        drive('0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        apply(mk(1'b1, 1'b0, 3'd3, 8'd70, 1'b0, 8'd65, 1'b0), "R8 tid3 after reset");
        // R6: marks on other IDs were cleared too (ID 1 was marked earlier).
        apply(mk(1'b1, 1'b0, 3'd1, 8'd70, 1'b0, 8'd65, 1'b0), "R6 tid1 after reset");
        // R5: write exactly at fence is not older.
        apply(mk(1'b0, 1'b0, 3'd5, 8'd80, 1'b0, 8'd80, 1'b1), "R5 equal tag");
        // R5: just below fence is older.
        apply(mk(1'b0, 1'b0, 3'd5, 8'd81, 1'b0, 8'd80, 1'b0), "R5 one older");

        @(negedge clk);
        drive('0);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule